// File: doc/BRIEF.md
# CFI Query and Identifier Read Responder

This block supplies the read data of a parallel flash bank while the bank sits in either identifier mode or query mode. The bank may be built from several narrow chips wired side by side, and each chip may be a wide part strapped to byte mode. The block turns the bus byte address into a table index by removing the address bits that the bank and device widths consume. It then looks up either a query-table byte or an identifier code. The result is copied into every device lane of the bank, so that the whole bank answers as a single device would. A read wider than the bank is assembled from consecutive lookups.

All widths are given as base-2 logarithms of a byte count: 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. The query table is a small fixed ROM of `TBL_DEPTH` entries. Its top entry is the parameter `END_BYTE`, and the identifier codes are parameters too. A read is requested with a one-cycle strobe. The registered data appears together with a one-cycle valid pulse on the following cycle.

Top module: `cfi_id_responder`

## Requirements
- R1: After reset, `rd_data` is 0, `rd_valid` is 0 and `cfg_err` is 0.
- R2: In query mode (`rd_query`=1), the table index is the byte address shifted right by `bank_lg + maxdev_lg - dev_lg`. Entries 0x10, 0x11 and 0x12 read as 0x51, 0x52 and 0x59 ("QRY").
- R3: An index of `TBL_DEPTH` (default 0x52) or above reads as zero in query mode. Index `TBL_DEPTH-1` reads as `END_BYTE`.
- R4: In identifier mode (`rd_query`=0), only the low 8 bits of the index are decoded. Index 0 gives `MFR_CODE`, index 1 gives `DEV_CODE`, and any other value gives zero. The code is cut or zero-extended to the device width.
- R5: The per-device value fills each device-width slot of the bank. For a native device wider than one byte, the query byte is zero-extended to the device width. Example: bank 4, device 2, byte 0x52 gives 0x00520052.
- R6: With device width 1 and a larger maximum device width (byte mode), every byte of the bank carries the query byte, not zero padding. The index shift includes `maxdev_lg`.
- R7: When the read width (`rd_size`) exceeds the bank width, chunk i is looked up at `rd_addr + i * bank width` and placed in bits `[i*bank*8 +: bank*8]`, with chunk 0 lowest. Result bytes at or above the read width are zero.
- R8: The configuration is unsupported in any of these cases: `bank_lg`, `maxdev_lg` or `rd_size` is above 2; `dev_lg` exceeds `maxdev_lg` or `bank_lg`; or, in query mode, `dev_lg` differs from `maxdev_lg` while `dev_lg` is not 0. A read under an unsupported configuration returns zero and sets `cfg_err`, which stays set until reset.
- R9: `rd_data` changes and `rd_valid` is 1 exactly one cycle after a cycle with `rd_stb`=1. Otherwise `rd_valid` is 0 and `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read request, one cycle |
| rd_query | input | 1 | 1 selects query mode, 0 selects identifier mode |
| rd_addr | input | ADDR_W | Bus byte address |
| rd_size | input | 2 | log2 of the read width in bytes |
| bank_lg | input | 2 | log2 of the bank width in bytes |
| dev_lg | input | 2 | log2 of the device width in bytes |
| maxdev_lg | input | 2 | log2 of the maximum device width in bytes |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Pulses for one cycle when rd_data is new |
| cfg_err | output | 1 | Sticky flag for an unsupported configuration |

## Verification
The checker assumes that the width inputs are steady during the strobe cycle and that `rd_stb` is a clean synchronous pulse. It checks only what follows from the ports over one cycle: the valid pulse, that the data holds between strobes, zero data and a set flag for an oversize bank, and zero upper bytes for one-byte reads. The bench changes the width inputs only together with the strobe, on the falling edge, and sweeps combinations that cover narrow, native-wide, byte-mode and unsupported banks. Each expected word in the bench is built by hand from the table bytes and codes named in the requirements.

// File: rtl/cfi_id_responder.sv
module cfi_id_responder #(
  parameter int          ADDR_W    = 16,
  parameter int          TBL_DEPTH = 82,
  parameter logic [15:0] MFR_CODE  = 16'h0089,
  parameter logic [15:0] DEV_CODE  = 16'h0018,
  parameter logic [7:0]  SIZE_LOG  = 8'h17,
  parameter logic [7:0]  END_BYTE  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              rd_query,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  input  logic [1:0]        bank_lg,
  input  logic [1:0]        dev_lg,
  input  logic [1:0]        maxdev_lg,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              cfg_err
);
  localparam int NBYTES = 4;

  function automatic logic [7:0] tbl_byte(input logic [ADDR_W-1:0] idx);
    logic [31:0] i;
    i = 32'(idx);
    if (i >= 32'(TBL_DEPTH)) return 8'h00;
    if (i == 32'(TBL_DEPTH - 1)) return END_BYTE;
    case (i)
      32'h10: return 8'h51;
      32'h11: return 8'h52;
      32'h12: return 8'h59;
      32'h13: return 8'h01;
      32'h15: return 8'h31;
      32'h1B: return 8'h45;
      32'h1C: return 8'h55;
      32'h1F: return 8'h07;
      32'h20: return 8'h07;
      32'h21: return 8'h0A;
      32'h23: return 8'h04;
      32'h24: return 8'h04;
      32'h25: return 8'h04;
      32'h27: return SIZE_LOG;
      32'h28: return 8'h02;
      32'h2A: return 8'h0B;
      32'h2C: return 8'h01;
      32'h31: return 8'h50;
      32'h32: return 8'h52;
      32'h33: return 8'h49;
      32'h34: return 8'h31;
      32'h35: return 8'h30;
      32'h3F: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  logic [2:0] shamt;
  logic       bad;
  logic [1:0] dmask;
  logic [3:0] nbytes;
  logic [31:0] base [NBYTES];
  logic [31:0] nxt;

  assign shamt  = {1'b0, bank_lg} + {1'b0, maxdev_lg} - {1'b0, dev_lg};
  assign dmask  = 2'((3'd1 << dev_lg) - 3'd1);
  assign nbytes = 4'd1 << rd_size;
  assign bad    = (bank_lg > 2'd2) || (maxdev_lg > 2'd2) || (rd_size > 2'd2) ||
                  (dev_lg > maxdev_lg) || (dev_lg > bank_lg) ||
                  (rd_query && (dev_lg != maxdev_lg) && (dev_lg != 2'd0));

  for (genvar k = 0; k < NBYTES; k++) begin : g_chunk
    logic [ADDR_W-1:0] caddr;
    logic [ADDR_W-1:0] idx;
    assign caddr = rd_addr + (ADDR_W'(k) << bank_lg);
    assign idx   = caddr >> shamt;
    assign base[k] = rd_query ? {24'h0, tbl_byte(idx)} :
                     (idx[7:0] == 8'd0) ? {16'h0, MFR_CODE} :
                     (idx[7:0] == 8'd1) ? {16'h0, DEV_CODE} : 32'h0;
  end

  for (genvar j = 0; j < NBYTES; j++) begin : g_lane
    logic [1:0] jj;
    logic [1:0] ch;
    logic [1:0] sub;
    assign jj  = 2'(j);
    assign ch  = jj >> bank_lg;
    assign sub = jj & dmask;
    assign nxt[j*8 +: 8] = (bad || (4'(j) >= nbytes)) ? 8'h00 : base[ch][{sub, 3'b000} +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) begin
        rd_data <= nxt;
        if (bad) cfg_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfi_id_responder_chk.sv
module cfi_id_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_stb,
  input logic [1:0]  rd_size,
  input logic [1:0]  bank_lg,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        cfg_err
);
  a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);
  a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  a_r8_wide_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && bank_lg == 2'd3) |=> (rd_data == 32'h0 && cfg_err));
  a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_size == 2'd0) |=> (rd_data[31:8] == 24'h0));
endmodule

bind cfi_id_responder cfi_id_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_size(rd_size), .bank_lg(bank_lg),
  .rd_data(rd_data), .rd_valid(rd_valid), .cfg_err(cfg_err)
);

// File: tb/sim_cfi_id_responder.sv
module sim_cfi_id_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_stb = 1'b0;
  logic        rd_query = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [1:0]  rd_size = '0, bank_lg = '0, dev_lg = '0, maxdev_lg = '0;
  logic [31:0] rd_data;
  logic        rd_valid, cfg_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfi_id_responder #(.END_BYTE(8'hC3)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_query(rd_query), .rd_addr(rd_addr),
    .rd_size(rd_size), .bank_lg(bank_lg), .dev_lg(dev_lg), .maxdev_lg(maxdev_lg),
    .rd_data(rd_data), .rd_valid(rd_valid), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input bit q, input logic [15:0] a, input logic [1:0] sz, input logic [1:0] b,
                    input logic [1:0] d, input logic [1:0] m, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_query = q; rd_addr = a; rd_size = sz; bank_lg = b; dev_lg = d; maxdev_lg = m; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check(rd_valid === 1'b1, {tag, " valid"}, {31'h0, rd_valid}, 32'h1);
    check(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(rd_data === 32'h0 && rd_valid === 1'b0 && cfg_err === 1'b0, "R1 reset state",
          {rd_data[29:0], rd_valid, cfg_err}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_query_basic();
    rd(1, 16'h0010, 0, 0, 0, 0, 32'h51, "R2 Q byte");
    rd(1, 16'h0011, 0, 0, 0, 0, 32'h52, "R2 R byte");
    rd(1, 16'h0012, 0, 0, 0, 0, 32'h59, "R2 Y byte");
  endtask

  task automatic t_replicate();
    rd(1, 16'h0020, 1, 1, 1, 1, 32'h0000_0051, "R5 native x16 zero extend");
    rd(1, 16'h0044, 2, 2, 1, 1, 32'h0052_0052, "R5 two x16 in x32 bank");
    rd(1, 16'h0040, 2, 2, 0, 0, 32'h5151_5151, "R5 four x8 in x32 bank");
  endtask

  task automatic t_bytemode();
    rd(1, 16'h0048, 1, 1, 0, 1, 32'h0000_5959, "R6 byte-mode x16 parts");
    rd(1, 16'h0088, 2, 2, 0, 1, 32'h5252_5252, "R6 byte-mode x32 bank");
  endtask

  task automatic t_wide_read();
    rd(1, 16'h0010, 2, 0, 0, 0, 32'h0159_5251, "R7 four chunks x8 bank");
    rd(1, 16'h0020, 2, 1, 1, 1, 32'h0052_0051, "R7 two chunks x16 bank");
    rd(1, 16'h0040, 0, 2, 0, 0, 32'h0000_0051, "R7 narrow read of x32 bank");
  endtask

  task automatic t_bounds();
    rd(1, 16'h0051, 0, 0, 0, 0, 32'hC3, "R3 last entry");
    rd(1, 16'h0052, 0, 0, 0, 0, 32'h00, "R3 first out of range");
    rd(1, 16'h0110, 0, 0, 0, 0, 32'h00, "R3 high address not aliased");
    rd(1, 16'h00A2, 1, 1, 1, 1, 32'h0000_00C3, "R3 last entry x16");
    rd(1, 16'h00A4, 1, 1, 1, 1, 32'h0, "R3 out of range x16");
  endtask

  task automatic t_ident();
    rd(0, 16'h0000, 1, 1, 1, 1, 32'h0000_0089, "R4 manufacturer");
    rd(0, 16'h0002, 1, 1, 1, 1, 32'h0000_0018, "R4 device");
    rd(0, 16'h0004, 1, 1, 1, 1, 32'h0, "R4 other index");
    rd(0, 16'h0200, 1, 1, 1, 1, 32'h0000_0089, "R4 low 8 index bits only");
    rd(0, 16'h0004, 2, 2, 1, 1, 32'h0018_0018, "R4 device in x32 bank");
    rd(0, 16'h0000, 1, 1, 0, 0, 32'h0000_8989, "R4 byte-wide parts");
    rd(0, 16'h0004, 1, 1, 0, 1, 32'h0000_1818, "R4 byte-mode shift");
  endtask

  task automatic t_cfg_err();
    check(cfg_err === 1'b0, "R8 no error on valid configs", {31'h0, cfg_err}, 32'h0);
    rd(1, 16'h0044, 2, 2, 1, 2, 32'h0, "R8 x16-mode of x32 part");
    check(cfg_err === 1'b1, "R8 flag set", {31'h0, cfg_err}, 32'h1);
    rd(1, 16'h0010, 0, 0, 0, 0, 32'h51, "R8 good read after error");
    check(cfg_err === 1'b1, "R8 flag sticky", {31'h0, cfg_err}, 32'h1);
    rd(1, 16'h0040, 2, 3, 0, 0, 32'h0, "R8 oversize bank");
    do_reset();
  endtask

  task automatic t_timing();
    logic [31:0] held;
    rd(1, 16'h0012, 0, 0, 0, 0, 32'h59, "R9 read");
    held = rd_data;
    rd_addr = 16'h0010;
    @(negedge clk);
    check(rd_valid === 1'b0, "R9 valid one cycle", {31'h0, rd_valid}, 32'h0);
    check(rd_data === held, "R9 data held", rd_data, held);
  endtask

  initial begin
    do_reset();
    t_query_basic();
    t_replicate();
    t_bytemode();
    t_wide_read();
    t_bounds();
    t_ident();
    t_timing();
    t_cfg_err();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule